// File: doc/BRIEF.md
# Prioritized Triple Transmit Slot Manager

This block sits between a host register bus and the frame transmitter of a CAN-style controller. It holds three outgoing message slots. Each slot keeps a 13-byte message record, an 8-bit local priority and a 16-bit completion stamp. The host finds a free slot from the per-slot empty flags. It points a select register at that slot and fills it through one shared register window. It then queues the slot by clearing the slot's empty flag. While the transmitter is free, the block offers the best queued slot. When a send finishes, the block frees the slot, stamps it and raises a per-slot interrupt flag. The bit-level protocol engine is reduced to a handshake of start, done and lost pulses.

The scheduler is a four-state machine. `ST_IDLE` moves to `ST_OFFER` (pick) once any queued slot without a pending abort exists. In `ST_OFFER` it re-arbitrates every cycle. It moves to `ST_SEND` (start) when the engine accepts, and falls back to `ST_IDLE` (drain) if aborts empty the queue. `ST_SEND` returns to `ST_IDLE` on done (complete) or moves to `ST_RETRY` on lost (lose). `ST_RETRY` behaves like `ST_IDLE`: it moves to `ST_OFFER` (re-pick) when a slot is ready, or to `ST_IDLE` when none is.

Host register addresses are 5 bits:

| Address | Register | Behaviour |
|---------|----------|-----------|
| 0x00 | EMPTY | Reads the empty flags in bits [2:0]. Writing 1 to a bit queues that slot. |
| 0x01 | SELECT | Written by the host; the read value is the resolved select (R2). |
| 0x02 | ABORT | Writing 1 to a bit requests an abort of that slot. |
| 0x03 | ACK | Read-only abort acknowledge bits. |
| 0x04 | IRQ | Interrupt flags; writing 1 to a bit clears it. |
| 0x10+k | Window byte | Message byte k, for k from 0 to 12. |
| 0x1D | Window priority | Local priority of the selected slot. |
| 0x1E | Stamp high | Upper byte of the completion stamp; read-only. |
| 0x1F | Stamp low | Lower byte of the completion stamp; read-only. |

Top module: `tx_slot_mgr`

## Requirements
- R1: After reset, EMPTY (0x00) reads 0x07, IRQ (0x04) reads 0, SELECT (0x01) reads 0, `irq` is low and `tx_valid` is low.
- R2: A read of SELECT (0x01) returns only the lowest-numbered bit that was last written as 1 and whose slot is empty, or 0 if there is no such bit; the window maps to that slot.
- R3: While the resolved select is nonzero, writes to 0x10+k (k = 0..12) store message byte k and a write to 0x1D stores the priority; reads of these addresses return the stored values of the mapped slot.
- R4: While the resolved select is zero, writes to window addresses leave every slot's contents unchanged.
- R5: Writing 1 to bit i of EMPTY clears the empty flag of slot i and queues it; `tx_valid` is only ever high for a queued slot, with `tx_msg` byte 0 in bits [7:0].
- R6: Among queued slots the numerically lowest priority value is offered first; on equal values the lower slot number wins.
- R7: A `tx_done` pulse while sending sets that slot's empty flag and its IRQ bit; writing 1 to an IRQ bit clears it, and `irq` is the OR of the IRQ bits.
- R8: On completion the slot captures a free-running cycle counter, readable at 0x1E (high) and 0x1F (low), so two stamps differ by the number of cycles between their completions.
- R9: An abort written to ABORT (0x02) for a queued slot that is not sending frees the slot and sets its bits in ACK (0x03) and IRQ; the ACK bit clears when the slot is queued again.
- R10: An abort for the slot being sent has no effect on that send: the slot stays queued until `tx_done` and its ACK bit stays 0.
- R11: A `tx_lost` pulse makes the block re-arbitrate over all queued slots, including slots queued during the failed send, before it offers again.
- R12: After `tx_done` with another slot ready, `tx_valid` rises on the second clock edge after the done edge.
- R13: An abort for an empty slot changes neither its empty flag nor ACK.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 5 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data for host_addr (combinational) |
| tx_valid | output | 1 | A queued slot is offered to the engine |
| tx_slot | output | 2 | Number of the offered or sending slot |
| tx_msg | output | 104 | Message record of tx_slot, byte k at bits [8k+7:8k] |
| tx_start | input | 1 | Engine accepted the offered slot |
| tx_done | input | 1 | Engine finished the current send |
| tx_lost | input | 1 | Engine lost arbitration on the current send |
| irq | output | 1 | OR of the per-slot interrupt flags |

## Verification
The assertions take for granted an engine that obeys the handshake. It pulses `tx_start` only while `tx_valid` is high, and pulses `tx_done` or `tx_lost` only while a send is in progress, never both together. The host also makes at most one register write per cycle. The bench's engine model only reacts to `tx_valid` seen at a falling edge. It holds each pulse for exactly one clock, and it waits out a fixed send length before it issues done or lost. All host traffic goes through a single write task, so the stimulus stays inside these limits.

// File: rtl/tx_mgr_pkg.sv
package tx_mgr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_OFFER,
        ST_SEND,
        ST_RETRY
    } sched_state_e;

    localparam int unsigned ADDR_W  = 5;
    localparam int unsigned PRIO_W  = 8;
    localparam int unsigned STAMP_W = 16;

    localparam logic [ADDR_W-1:0] A_EMPTY    = 5'h00;
    localparam logic [ADDR_W-1:0] A_SELECT   = 5'h01;
    localparam logic [ADDR_W-1:0] A_ABORT    = 5'h02;
    localparam logic [ADDR_W-1:0] A_ACK      = 5'h03;
    localparam logic [ADDR_W-1:0] A_IRQ      = 5'h04;
    localparam logic [ADDR_W-1:0] A_WIN_BASE = 5'h10;
    localparam logic [ADDR_W-1:0] A_PRIO     = 5'h1D;
    localparam logic [ADDR_W-1:0] A_STAMP_HI = 5'h1E;
    localparam logic [ADDR_W-1:0] A_STAMP_LO = 5'h1F;

endpackage

// File: rtl/tx_slot_store.sv
module tx_slot_store
    import tx_mgr_pkg::*;
#(
    parameter int unsigned MSG_BYTES = 13,
    parameter int unsigned IDX_W     = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   byte_we,
    input  logic [IDX_W-1:0]       byte_idx,
    input  logic [7:0]             wr_data,
    input  logic                   prio_we,
    input  logic                   stamp_we,
    input  logic [STAMP_W-1:0]     stamp_in,
    output logic [MSG_BYTES*8-1:0] msg_flat,
    output logic [PRIO_W-1:0]      prio,
    output logic [STAMP_W-1:0]     stamp
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(MSG_BYTES - 1);

    logic [7:0]         bytes_q [MSG_BYTES];
    logic [PRIO_W-1:0]  prio_q;
    logic [STAMP_W-1:0] stamp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < int'(MSG_BYTES); b++) begin
                bytes_q[b] <= '0;
            end
        end else if (byte_we && byte_idx <= LAST_IDX) begin
            bytes_q[byte_idx] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prio_q  <= '0;
            stamp_q <= '0;
        end else begin
            if (prio_we) begin
                prio_q <= wr_data;
            end
            if (stamp_we) begin
                stamp_q <= stamp_in;
            end
        end
    end

    for (genvar b = 0; b < int'(MSG_BYTES); b++) begin : g_flat
        assign msg_flat[b*8 +: 8] = bytes_q[b];
    end

    assign prio  = prio_q;
    assign stamp = stamp_q;

endmodule

// File: rtl/tx_prio_arb.sv
module tx_prio_arb
    import tx_mgr_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 3,
    parameter int unsigned SLOT_W    = 2
) (
    input  logic [NUM_SLOTS-1:0]        ready,
    input  logic [NUM_SLOTS*PRIO_W-1:0] prio_flat,
    output logic                        best_valid,
    output logic [SLOT_W-1:0]           best_slot
);

    logic [PRIO_W-1:0] best_prio;

    // Strict less-than keeps the lower slot number on equal priorities.
    always_comb begin
        best_valid = 1'b0;
        best_slot  = '0;
        best_prio  = '0;
        for (int i = 0; i < int'(NUM_SLOTS); i++) begin
            if (ready[i] && (!best_valid || prio_flat[i*PRIO_W +: PRIO_W] < best_prio)) begin
                best_valid = 1'b1;
                best_slot  = SLOT_W'(i);
                best_prio  = prio_flat[i*PRIO_W +: PRIO_W];
            end
        end
    end

endmodule

// File: rtl/tx_sched_fsm.sv
module tx_sched_fsm
    import tx_mgr_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 3,
    parameter int unsigned SLOT_W    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SLOTS-1:0] queue_set,
    input  logic [NUM_SLOTS-1:0] abort_set,
    input  logic [NUM_SLOTS-1:0] irq_clr,
    input  logic                 best_valid,
    input  logic [SLOT_W-1:0]    best_slot,
    input  logic                 tx_start,
    input  logic                 tx_done,
    input  logic                 tx_lost,
    output logic [NUM_SLOTS-1:0] ready_mask,
    output logic [NUM_SLOTS-1:0] empty_flags,
    output logic [NUM_SLOTS-1:0] abort_pend,
    output logic [NUM_SLOTS-1:0] abort_ack,
    output logic [NUM_SLOTS-1:0] irq_flags,
    output logic [NUM_SLOTS-1:0] stamp_we,
    output logic                 tx_valid,
    output logic                 sending,
    output logic [SLOT_W-1:0]    cur_slot
);

    sched_state_e state_q, state_d;
    logic [SLOT_W-1:0]    cur_q, cur_d;
    logic [NUM_SLOTS-1:0] empty_q, pend_q, ack_q, irq_q;
    logic [NUM_SLOTS-1:0] cur_oh, locked, kill, done_oh;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cur_q   <= '0;
        end else begin
            state_q <= state_d;
            cur_q   <= cur_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        cur_d   = cur_q;
        unique case (state_q)
            ST_IDLE, ST_RETRY: begin
                if (best_valid) begin
                    state_d = ST_OFFER;
                    cur_d   = best_slot;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_OFFER: begin
                if (tx_start) begin
                    state_d = ST_SEND;
                end else if (best_valid) begin
                    cur_d = best_slot;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_SEND: begin
                if (tx_done) begin
                    state_d = ST_IDLE;
                end else if (tx_lost) begin
                    state_d = ST_RETRY;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        for (int i = 0; i < int'(NUM_SLOTS); i++) begin
            cur_oh[i] = (cur_q == SLOT_W'(i));
        end
        tx_valid = (state_q == ST_OFFER);
        sending  = (state_q == ST_SEND);
        locked   = (sending || (tx_valid && tx_start)) ? cur_oh : '0;
        done_oh  = (sending && tx_done) ? cur_oh : '0;
        kill     = pend_q & ~empty_q & ~locked;
        ready_mask = ~empty_q & ~kill;
        stamp_we = done_oh;
        cur_slot = cur_q;
    end

    // Per-slot flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            empty_q <= '1;
            pend_q  <= '0;
            ack_q   <= '0;
            irq_q   <= '0;
        end else begin
            empty_q <= (empty_q & ~queue_set) | kill | done_oh;
            pend_q  <= (pend_q & ~kill & ~done_oh & ~empty_q) | abort_set;
            ack_q   <= (ack_q & ~queue_set) | kill;
            irq_q   <= (irq_q & ~irq_clr) | kill | done_oh;
        end
    end

    assign empty_flags = empty_q;
    assign abort_pend  = pend_q;
    assign abort_ack   = ack_q;
    assign irq_flags   = irq_q;

endmodule

// File: rtl/tx_slot_mgr.sv
module tx_slot_mgr
    import tx_mgr_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 3,
    parameter int unsigned MSG_BYTES = 13
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   host_we,
    input  logic [4:0]             host_addr,
    input  logic [7:0]             host_wdata,
    output logic [7:0]             host_rdata,
    output logic                   tx_valid,
    output logic [1:0]             tx_slot,
    output logic [MSG_BYTES*8-1:0] tx_msg,
    input  logic                   tx_start,
    input  logic                   tx_done,
    input  logic                   tx_lost,
    output logic                   irq
);

    localparam int unsigned SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
    localparam int unsigned IDX_W    = 4;
    localparam int unsigned MSG_BITS = MSG_BYTES * 8;
    localparam logic [ADDR_W-1:0] A_WIN_LAST = A_WIN_BASE + ADDR_W'(MSG_BYTES - 1);

    logic [NUM_SLOTS-1:0] sel_raw, sel_res;
    logic                 sel_hit;
    logic [SLOT_W-1:0]    sel_idx;
    logic [NUM_SLOTS-1:0] empty_flags, abort_pend, abort_ack, irq_flags;
    logic [NUM_SLOTS-1:0] queue_set, abort_set, irq_clr, ready_mask, stamp_we;
    logic                 best_valid, sending;
    logic [SLOT_W-1:0]    best_slot, cur_slot;
    logic [STAMP_W-1:0]   stamp_cnt;
    logic                 in_window;
    logic [IDX_W-1:0]     win_idx;
    logic [MSG_BITS-1:0]  slot_msg   [NUM_SLOTS];
    logic [PRIO_W-1:0]    slot_prio  [NUM_SLOTS];
    logic [STAMP_W-1:0]   slot_stamp [NUM_SLOTS];
    logic [NUM_SLOTS*PRIO_W-1:0] prio_flat;

    // Select register and its resolution against the empty flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_raw <= '0;
        end else if (host_we && host_addr == A_SELECT) begin
            sel_raw <= host_wdata[NUM_SLOTS-1:0];
        end
    end

    always_comb begin
        sel_res = '0;
        sel_hit = 1'b0;
        sel_idx = '0;
        for (int i = 0; i < int'(NUM_SLOTS); i++) begin
            if (!sel_hit && sel_raw[i] && empty_flags[i]) begin
                sel_hit    = 1'b1;
                sel_res[i] = 1'b1;
                sel_idx    = SLOT_W'(i);
            end
        end
    end

    // Free-running stamp source
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stamp_cnt <= '0;
        end else begin
            stamp_cnt <= stamp_cnt + 1'b1;
        end
    end

    assign in_window = (host_addr >= A_WIN_BASE) && (host_addr <= A_WIN_LAST);
    assign win_idx   = IDX_W'(host_addr - A_WIN_BASE);

    assign queue_set = (host_we && host_addr == A_EMPTY) ? host_wdata[NUM_SLOTS-1:0] & empty_flags : '0;
    assign abort_set = (host_we && host_addr == A_ABORT) ? host_wdata[NUM_SLOTS-1:0] : '0;
    assign irq_clr   = (host_we && host_addr == A_IRQ)   ? host_wdata[NUM_SLOTS-1:0] : '0;

    for (genvar s = 0; s < int'(NUM_SLOTS); s++) begin : g_slot
        tx_slot_store #(
            .MSG_BYTES(MSG_BYTES),
            .IDX_W    (IDX_W)
        ) i_store (
            .clk     (clk),
            .rst_n   (rst_n),
            .byte_we (host_we && in_window && sel_res[s]),
            .byte_idx(win_idx),
            .wr_data (host_wdata),
            .prio_we (host_we && host_addr == A_PRIO && sel_res[s]),
            .stamp_we(stamp_we[s]),
            .stamp_in(stamp_cnt),
            .msg_flat(slot_msg[s]),
            .prio    (slot_prio[s]),
            .stamp   (slot_stamp[s])
        );
        assign prio_flat[s*PRIO_W +: PRIO_W] = slot_prio[s];
    end

    tx_prio_arb #(
        .NUM_SLOTS(NUM_SLOTS),
        .SLOT_W   (SLOT_W)
    ) i_arb (
        .ready     (ready_mask),
        .prio_flat (prio_flat),
        .best_valid(best_valid),
        .best_slot (best_slot)
    );

    tx_sched_fsm #(
        .NUM_SLOTS(NUM_SLOTS),
        .SLOT_W   (SLOT_W)
    ) i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .queue_set  (queue_set),
        .abort_set  (abort_set),
        .irq_clr    (irq_clr),
        .best_valid (best_valid),
        .best_slot  (best_slot),
        .tx_start   (tx_start),
        .tx_done    (tx_done),
        .tx_lost    (tx_lost),
        .ready_mask (ready_mask),
        .empty_flags(empty_flags),
        .abort_pend (abort_pend),
        .abort_ack  (abort_ack),
        .irq_flags  (irq_flags),
        .stamp_we   (stamp_we),
        .tx_valid   (tx_valid),
        .sending    (sending),
        .cur_slot   (cur_slot)
    );

    // Host read path
    always_comb begin
        host_rdata = '0;
        if (in_window) begin
            if (sel_hit) begin
                host_rdata = slot_msg[sel_idx][{win_idx, 3'b000} +: 8];
            end
        end else begin
            case (host_addr)
                A_EMPTY:    host_rdata = 8'(empty_flags);
                A_SELECT:   host_rdata = 8'(sel_res);
                A_ABORT:    host_rdata = 8'(abort_pend);
                A_ACK:      host_rdata = 8'(abort_ack);
                A_IRQ:      host_rdata = 8'(irq_flags);
                A_PRIO:     host_rdata = sel_hit ? slot_prio[sel_idx] : '0;
                A_STAMP_HI: host_rdata = sel_hit ? slot_stamp[sel_idx][15:8] : '0;
                A_STAMP_LO: host_rdata = sel_hit ? slot_stamp[sel_idx][7:0] : '0;
                default:    host_rdata = '0;
            endcase
        end
    end

    assign tx_slot = 2'(cur_slot);
    assign tx_msg  = slot_msg[cur_slot];
    assign irq     = |irq_flags;

endmodule

// File: rtl/tx_slot_mgr_chk.sv
module tx_slot_mgr_chk #(
    parameter int unsigned N  = 3,
    parameter int unsigned SW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tx_valid,
    input logic [1:0]    tx_slot,
    input logic          tx_start,
    input logic          tx_done,
    input logic          tx_lost,
    input logic          sending,
    input logic [N-1:0]  empty,
    input logic [N-1:0]  abort_req,
    input logic [N-1:0]  abort_ack
);

    // R5
    offered_queued_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> ((empty >> tx_slot) & N'(1)) == '0);

    // R10
    send_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sending && !tx_done && !tx_lost) |=> (sending && $stable(tx_slot)
            && ((empty >> tx_slot) & N'(1)) == '0));

    // R7
    done_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sending && tx_done) |=> ((empty >> $past(tx_slot)) & N'(1)) != '0);

    // R9
    ack_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_ack & ~$past(abort_ack) & ~empty) == '0);

    // R11
    lost_regap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sending && tx_lost) |=> (!sending && !tx_valid));

    // R12
    prompt_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sending && !tx_valid && (~empty & ~abort_req) != '0) |=> tx_valid);

endmodule

bind tx_slot_mgr tx_slot_mgr_chk #(
    .N (NUM_SLOTS),
    .SW(SLOT_W)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_valid (tx_valid),
    .tx_slot  (tx_slot),
    .tx_start (tx_start),
    .tx_done  (tx_done),
    .tx_lost  (tx_lost),
    .sending  (sending),
    .empty    (empty_flags),
    .abort_req(abort_pend),
    .abort_ack(abort_ack)
);

// File: tb/test_tx_slot_mgr.sv
module test_tx_slot_mgr;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         host_we = 1'b0;
    logic [4:0]   host_addr = '0;
    logic [7:0]   host_wdata = '0;
    logic [7:0]   host_rdata;
    logic         tx_valid;
    logic [1:0]   tx_slot;
    logic [103:0] tx_msg;
    logic         tx_start = 1'b0;
    logic         tx_done = 1'b0;
    logic         tx_lost = 1'b0;
    logic         irq;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit finished = 1'b0;

    bit eng_en = 1'b0;
    bit eng_lose = 1'b0;
    int eng_hold = 3;
    int start_cyc [3];
    int done_cyc [3];
    int last_done = -100;
    int b2b_gap = -1;
    int exp_q [$];

    always #5 clk = ~clk;

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    tx_slot_mgr i_tx_slot_mgr (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .tx_valid(tx_valid),
        .tx_slot(tx_slot), .tx_msg(tx_msg), .tx_start(tx_start),
        .tx_done(tx_done), .tx_lost(tx_lost), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output int v);
        @(negedge clk);
        host_addr = a;
        #1 v = int'(host_rdata);
    endtask

    task automatic load_slot(input int s, input int pr);
        wr(5'h01, 8'(1 << s));
        for (int k = 0; k < 13; k++) wr(5'(16 + k), 8'(8'hA0 + s + 16 * k));
        wr(5'h1D, 8'(pr));
    endtask

    task automatic wait_empty(input int mask);
        int v;
        for (int n = 0; n < 400; n++) begin
            rd(5'h00, v);
            if ((v & mask) == mask) break;
        end
    endtask

    function automatic int stamp_of(input int s);
        return 0;
    endfunction

    task automatic read_stamp(input int s, output int st);
        int hi, lo;
        wr(5'h01, 8'(1 << s));
        rd(5'h1E, hi);
        rd(5'h1F, lo);
        st = hi * 256 + lo;
    endtask

    // Engine model and scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (eng_en && tx_valid) begin
                int want;
                int s;
                s = int'(tx_slot);
                want = (exp_q.size() > 0) ? exp_q.pop_front() : -1;
                check("R6 send order", s, want);
                check("R5 tx_msg byte0", int'(tx_msg[7:0]), 8'hA0 + s);
                start_cyc[s] = cyc;
                if (cyc - last_done == 2) b2b_gap = 2;
                tx_start = 1'b1;
                @(negedge clk);
                tx_start = 1'b0;
                repeat (eng_hold) @(negedge clk);
                if (eng_lose) begin
                    tx_lost = 1'b1;
                    eng_lose = 1'b0;
                end else begin
                    tx_done = 1'b1;
                    done_cyc[s] = cyc;
                    last_done = cyc;
                end
                @(negedge clk);
                tx_lost = 1'b0;
                tx_done = 1'b0;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int v, s1, s2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(5'h00, v); check("R1 empty", v, 7);
        rd(5'h04, v); check("R1 irq flags", v, 0);
        rd(5'h01, v); check("R1 select", v, 0);
        check("R1 irq pin", int'(irq), 0);
        check("R1 tx_valid", int'(tx_valid), 0);

        // R2 select resolution
        wr(5'h01, 8'h06); rd(5'h01, v); check("R2 lowest set", v, 2);
        wr(5'h01, 8'h00); rd(5'h01, v); check("R2 none", v, 0);

        // R3 window write and read back
        load_slot(0, 5); load_slot(1, 2); load_slot(2, 2);
        wr(5'h01, 8'h01);
        rd(5'h15, v); check("R3 byte5", v, 8'hA0 + 80);
        rd(5'h1D, v); check("R3 prio", v, 5);

        // R4 writes ignored with no slot mapped
        wr(5'h01, 8'h00);
        wr(5'h10, 8'hFF);
        wr(5'h1D, 8'hEE);
        wr(5'h01, 8'h01);
        rd(5'h10, v); check("R4 byte0 kept", v, 8'hA0);
        rd(5'h1D, v); check("R4 prio kept", v, 5);

        // R6 priority order with tie, R12 back to back, R7, R8
        exp_q.push_back(1); exp_q.push_back(2); exp_q.push_back(0);
        wr(5'h00, 8'h07);
        rd(5'h00, v); check("R5 queued", v, 0);
        eng_en = 1'b1;
        wait_empty(7);
        check("R6 queue drained", exp_q.size(), 0);
        check("R12 back-to-back gap", b2b_gap, 2);
        rd(5'h04, v); check("R7 irq flags", v, 7);
        check("R7 irq pin", int'(irq), 1);
        wr(5'h04, 8'h05);
        rd(5'h04, v); check("R7 w1c", v, 2);
        wr(5'h04, 8'h02);
        check("R7 irq pin low", int'(irq), 0);
        read_stamp(1, s1); read_stamp(2, s2);
        check("R8 stamp delta", s2 - s1, done_cyc[2] - done_cyc[1]);

        // R9 abort of offered but not started slot
        eng_en = 1'b0;
        wr(5'h00, 8'h01);
        repeat (3) @(negedge clk);
        check("R9 offered", int'(tx_valid), 1);
        wr(5'h02, 8'h01);
        repeat (2) @(negedge clk);
        rd(5'h00, v); check("R9 freed", v & 1, 1);
        rd(5'h03, v); check("R9 ack", v, 1);
        rd(5'h04, v); check("R9 irq", v, 1);
        check("R9 no offer", int'(tx_valid), 0);
        wr(5'h04, 8'h07);

        // R13 abort of empty slot
        wr(5'h02, 8'h04);
        repeat (2) @(negedge clk);
        rd(5'h00, v); check("R13 empty kept", v, 7);
        rd(5'h03, v); check("R13 ack kept", v, 1);

        // R10 abort of slot being sent
        eng_hold = 20; eng_en = 1'b1;
        exp_q.push_back(1);
        wr(5'h00, 8'h02);
        repeat (5) @(negedge clk);
        wr(5'h02, 8'h02);
        rd(5'h00, v); check("R10 still queued", v & 2, 0);
        wait_empty(7);
        rd(5'h03, v); check("R10 no ack", v & 2, 0);
        rd(5'h04, v); check("R10 done irq", v & 2, 2);
        wr(5'h04, 8'h07);

        // R11 lost arbitration re-evaluates
        eng_en = 1'b0;
        load_slot(0, 9); load_slot(2, 1);
        exp_q.push_back(0); exp_q.push_back(2); exp_q.push_back(0);
        eng_hold = 10; eng_lose = 1'b1;
        wr(5'h00, 8'h01);
        rd(5'h03, v); check("R9 ack cleared on queue", v & 1, 0);
        eng_en = 1'b1;
        repeat (4) @(negedge clk);
        wr(5'h00, 8'h04);
        wait_empty(7);
        check("R11 order done", exp_q.size(), 0);
        check("R11 slot2 before slot0", int'(start_cyc[2] < start_cyc[0]), 1);

        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule